// File: doc/BRIEF.md
# Column Driver Pixel Sampling Front End

This block is the digital input side of a thin-film panel column driver. A start pulse arms a sampling pointer, which then walks across the driver's pixel slots one step per shift clock. At each step the pixel code presented on the colour inputs is first caught in an input register and, one edge later, written into the slot the pointer names in a sampling store. Each slot is one RGB triplet holding three 6-bit codes. When the line is complete, a line strobe copies the whole sampling store into a hold bank in a single edge. The hold bank feeds the conversion stage and is the output of this block. The sampling store can then fill with the next line while the hold bank stays fixed.

Four configurations set how many triplets are active and how many pixels arrive per clock. In the two dual-port configurations, two pixels arrive per clock. In the two single-port configurations, one pixel arrives per clock. A direction input reverses the sampling order. It also swaps the roles of the two start-pulse pins. One pin takes the incoming start pulse, and the other emits a one-cycle cascade pulse that starts the next driver in the chain.

Top module: `column_sample_front`

## Requirements
- R1: While `rst` is high at a clock edge, every hold code becomes 0 and both cascade outputs go low.
- R2: `mode_i` selects the active triplet count and the port use: 0 gives 108 triplets with dual ports (54 groups), 1 gives 107 triplets with a single port (107 groups), 2 gives 104 triplets with dual ports (52 groups), and 3 gives 103 triplets with a single port (103 groups).
- R3: In forward order (`rev_i`=0) with dual ports, group j writes port A to triplet index 2j and port B to triplet index 2j+1. Indices count from 0.
- R4: With a single port, group j uses only port A. The port B inputs have no effect on the hold codes.
- R5: In reverse order (`rev_i`=1) with N active triplets, dual-port group j writes port A to index N-1-2j and port B to index N-2-2j. Single-port group j writes index N-1-j.
- R6: Group 0 is the data present at the edge that samples the start pulse. Group j is the data present j edges later.
- R7: The pin on the output side drives a cascade pulse that is high for exactly one cycle, beginning right after the edge that samples the last group of the line. The output side is the right pin in forward order and the left pin in reverse order. Its enable is 1 and the input-side enable is 0. No other cascade pulse appears.
- R8: A strobe on `lat_i` loads the hold bank with the sampling store as it stood before that edge. A group written on the same edge is not included.
- R9: Without a strobe, the hold codes do not change while the sampling store fills.
- R10: Triplets beyond the active count, and data presented after the last group of a line, leave the sampling store unchanged.
- R11: A start pulse on the output-side pin starts no sampling and produces no cascade pulse.
- R12: The hold bank is laid out with triplet i at bits [18i+17:18i]. Within a triplet, red is in [5:0], green in [11:6] and blue in [17:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Triplet count and port-use select |
| rev_i | input | 1 | Sampling direction, 1 = reverse |
| sp_left_i | input | 1 | Left start-pulse pin, input value |
| sp_right_i | input | 1 | Right start-pulse pin, input value |
| sp_left_o | output | 1 | Left pin cascade drive |
| sp_left_oe | output | 1 | Left pin drive enable |
| sp_right_o | output | 1 | Right pin cascade drive |
| sp_right_oe | output | 1 | Right pin drive enable |
| a_red_i | input | 6 | Port A red code |
| a_grn_i | input | 6 | Port A green code |
| a_blu_i | input | 6 | Port A blue code |
| b_red_i | input | 6 | Port B red code |
| b_grn_i | input | 6 | Port B green code |
| b_blu_i | input | 6 | Port B blue code |
| lat_i | input | 1 | Line strobe |
| hold_o | output | 1944 | Hold bank codes |

## Verification
A pixel group presented at edge k enters the sampling store at edge k+1. The cascade pulse is visible in the cycle after the edge that captures the last group. A strobe at edge k shows in `hold_o` during the cycle after k. The bench changes inputs and reads outputs only on the falling edge, half a cycle away from each rising edge. It counts falling edges from the start pulse to know where each result must appear. The scoreboard holds a store image that is updated group by group, so the image pushed with a strobe already excludes any group still in flight on that edge.

// File: rtl/csf_pkg.sv
package csf_pkg;

  typedef enum logic [1:0] {
    CSF_FULL_DUAL   = 2'd0,
    CSF_FULL_SINGLE = 2'd1,
    CSF_CUT_DUAL    = 2'd2,
    CSF_CUT_SINGLE  = 2'd3
  } csf_mode_e;

  function automatic logic csf_is_dual(csf_mode_e m);
    return (m == CSF_FULL_DUAL) || (m == CSF_CUT_DUAL);
  endfunction

  // active triplet count for a configuration
  function automatic int csf_active_trip(csf_mode_e m, int full, int cut);
    case (m)
      CSF_FULL_DUAL:   return full;
      CSF_FULL_SINGLE: return full - 1;
      CSF_CUT_DUAL:    return full - cut;
      default:         return full - cut - 1;
    endcase
  endfunction

endpackage

// File: rtl/csf_pointer.sv
module csf_pointer
  import csf_pkg::*;
#(
  parameter int NUM_TRIP = 108,
  parameter int CUT_TRIP = 4,
  parameter int IDX_W    = $clog2(NUM_TRIP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             rev,
  input  logic             start,
  output logic             wr_v,
  output logic [IDX_W-1:0] slot_a,
  output logic [IDX_W-1:0] slot_b,
  output logic             b_en,
  output logic             casc_q
);

  csf_mode_e        cfg;
  logic             active_q, act_nx;
  logic [IDX_W-1:0] grp_q, grp_nx, last_grp;
  logic             dual;
  int               n_trip, n_grp, base, sa, sb;

  assign cfg = csf_mode_e'(mode);

  always_comb begin
    dual     = csf_is_dual(cfg);
    n_trip   = csf_active_trip(cfg, NUM_TRIP, CUT_TRIP);
    n_grp    = dual ? (n_trip / 2) : n_trip;
    last_grp = IDX_W'(n_grp - 1);
    base     = dual ? (2 * int'(grp_q)) : int'(grp_q);
    sa       = rev ? (n_trip - 1 - base) : base;
    sb       = rev ? (sa - 1) : (sa + 1);
  end

  assign slot_a = IDX_W'(sa);
  assign slot_b = IDX_W'(sb);
  assign b_en   = dual;
  assign wr_v   = active_q;

  always_comb begin
    act_nx = active_q;
    grp_nx = grp_q;
    if (start) begin
      act_nx = 1'b1;
      grp_nx = '0;
    end else if (active_q) begin
      if (grp_q == last_grp) act_nx = 1'b0;
      else                   grp_nx = grp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      grp_q    <= '0;
      casc_q   <= 1'b0;
    end else begin
      active_q <= act_nx;
      grp_q    <= grp_nx;
      // high while the last group is being captured: next device starts gapless
      casc_q   <= act_nx && (grp_nx == last_grp);
    end
  end

endmodule

// File: rtl/csf_in_latch.sv
module csf_in_latch #(
  parameter int PIX_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] da,
  input  logic [PIX_W-1:0] db,
  output logic [PIX_W-1:0] qa,
  output logic [PIX_W-1:0] qb
);

  always_ff @(posedge clk) begin
    if (rst) begin
      qa <= '0;
      qb <= '0;
    end else begin
      qa <= da;
      qb <= db;
    end
  end

endmodule

// File: rtl/csf_store.sv
module csf_store #(
  parameter int NUM_TRIP = 108,
  parameter int PIX_W    = 18,
  parameter int IDX_W    = $clog2(NUM_TRIP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_v,
  input  logic [IDX_W-1:0]          slot_a,
  input  logic [IDX_W-1:0]          slot_b,
  input  logic                      b_en,
  input  logic [PIX_W-1:0]          da,
  input  logic [PIX_W-1:0]          db,
  input  logic                      lat,
  output logic [NUM_TRIP*PIX_W-1:0] hold
);

  logic [NUM_TRIP*PIX_W-1:0] samp_flat;

  for (genvar i = 0; i < NUM_TRIP; i++) begin : g_slot
    logic [PIX_W-1:0] cell_q;
    logic             hit_a, hit_b;

    assign hit_a = wr_v && (slot_a == IDX_W'(i));
    assign hit_b = wr_v && b_en && (slot_b == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)        cell_q <= '0;
      else if (hit_a) cell_q <= da;
      else if (hit_b) cell_q <= db;
    end

    assign samp_flat[i*PIX_W +: PIX_W] = cell_q;
  end

  // whole-line transfer; sees the store before this edge's write
  always_ff @(posedge clk) begin
    if (rst)      hold <= '0;
    else if (lat) hold <= samp_flat;
  end

endmodule

// File: rtl/column_sample_front.sv
module column_sample_front #(
  parameter int NUM_TRIP = 108,
  parameter int CUT_TRIP = 4,
  parameter int CODE_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   mode_i,
  input  logic                         rev_i,
  input  logic                         sp_left_i,
  input  logic                         sp_right_i,
  output logic                         sp_left_o,
  output logic                         sp_left_oe,
  output logic                         sp_right_o,
  output logic                         sp_right_oe,
  input  logic [CODE_W-1:0]            a_red_i,
  input  logic [CODE_W-1:0]            a_grn_i,
  input  logic [CODE_W-1:0]            a_blu_i,
  input  logic [CODE_W-1:0]            b_red_i,
  input  logic [CODE_W-1:0]            b_grn_i,
  input  logic [CODE_W-1:0]            b_blu_i,
  input  logic                         lat_i,
  output logic [NUM_TRIP*3*CODE_W-1:0] hold_o
);

  localparam int PIX_W = 3 * CODE_W;
  localparam int IDX_W = $clog2(NUM_TRIP);

  logic             start;
  logic             wr_v, b_en, casc_q;
  logic [IDX_W-1:0] slot_a, slot_b;
  logic [PIX_W-1:0] qa, qb;

  assign start = rev_i ? sp_right_i : sp_left_i;

  csf_pointer #(
    .NUM_TRIP(NUM_TRIP), .CUT_TRIP(CUT_TRIP), .IDX_W(IDX_W)
  ) ptr_i (
    .clk(clk), .rst(rst), .mode(mode_i), .rev(rev_i), .start(start),
    .wr_v(wr_v), .slot_a(slot_a), .slot_b(slot_b), .b_en(b_en),
    .casc_q(casc_q)
  );

  csf_in_latch #(.PIX_W(PIX_W)) lat_in_i (
    .clk(clk), .rst(rst),
    .da({a_blu_i, a_grn_i, a_red_i}),
    .db({b_blu_i, b_grn_i, b_red_i}),
    .qa(qa), .qb(qb)
  );

  csf_store #(
    .NUM_TRIP(NUM_TRIP), .PIX_W(PIX_W), .IDX_W(IDX_W)
  ) store_i (
    .clk(clk), .rst(rst), .wr_v(wr_v), .slot_a(slot_a), .slot_b(slot_b),
    .b_en(b_en), .da(qa), .db(qb), .lat(lat_i), .hold(hold_o)
  );

  assign sp_right_oe = ~rev_i;
  assign sp_left_oe  = rev_i;
  assign sp_right_o  = casc_q & ~rev_i;
  assign sp_left_o   = casc_q & rev_i;

endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
  parameter int HOLD_W = 1944
) (
  input logic              clk,
  input logic              rst,
  input logic              lat_i,
  input logic [HOLD_W-1:0] hold_o,
  input logic              sp_left_o,
  input logic              sp_left_oe,
  input logic              sp_right_o,
  input logic              sp_right_oe
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (hold_o == '0) && !sp_left_o && !sp_right_o);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !lat_i |=> $stable(hold_o));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (sp_left_o || sp_right_o) |=> !(sp_left_o || sp_right_o));

  a_r7_one_driver: assert property (@(posedge clk) disable iff (rst)
    sp_left_oe != sp_right_oe);

  a_r7_drive_when_enabled: assert property (@(posedge clk) disable iff (rst)
    (sp_left_o -> sp_left_oe) && (sp_right_o -> sp_right_oe));

endmodule

bind column_sample_front csf_checker #(.HOLD_W(NUM_TRIP*3*CODE_W)) chk_i (
  .clk(clk), .rst(rst), .lat_i(lat_i), .hold_o(hold_o),
  .sp_left_o(sp_left_o), .sp_left_oe(sp_left_oe),
  .sp_right_o(sp_right_o), .sp_right_oe(sp_right_oe)
);

// File: tb/column_sample_front_tb.sv
`timescale 1ns/1ps
module column_sample_front_tb_top;

  localparam int NT = 108;
  localparam int CW = 6;
  localparam int PW = 3 * CW;
  localparam int HW = NT * PW;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode_i;
  logic          rev_i, sp_left_i, sp_right_i, lat_i;
  logic          sp_left_o, sp_left_oe, sp_right_o, sp_right_oe;
  logic [CW-1:0] a_red_i, a_grn_i, a_blu_i, b_red_i, b_grn_i, b_blu_i;
  logic [HW-1:0] hold_o;

  always #4 clk = ~clk;

  column_sample_front dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .rev_i(rev_i),
    .sp_left_i(sp_left_i), .sp_right_i(sp_right_i),
    .sp_left_o(sp_left_o), .sp_left_oe(sp_left_oe),
    .sp_right_o(sp_right_o), .sp_right_oe(sp_right_oe),
    .a_red_i(a_red_i), .a_grn_i(a_grn_i), .a_blu_i(a_blu_i),
    .b_red_i(b_red_i), .b_grn_i(b_grn_i), .b_blu_i(b_blu_i),
    .lat_i(lat_i), .hold_o(hold_o)
  );

  typedef struct {
    logic [HW-1:0] img;
    string         tag;
  } sb_item_t;

  sb_item_t      sbq[$];
  logic [PW-1:0] exp_mem [NT];
  logic [HW-1:0] last_img = '0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] model_img();
    logic [HW-1:0] r;
    for (int i = 0; i < NT; i++) r[i*PW +: PW] = exp_mem[i];
    return r;
  endfunction

  function automatic logic [CW-1:0] gen(int seed, int g, int port, int col);
    return CW'((seed * 13 + g * 5 + port * 31 + col * 19 + 1) % 64);
  endfunction

  task automatic drive_data(input int seed, input int g);
    a_red_i = gen(seed, g, 0, 0); a_grn_i = gen(seed, g, 0, 1); a_blu_i = gen(seed, g, 0, 2);
    b_red_i = gen(seed, g, 1, 0); b_grn_i = gen(seed, g, 1, 1); b_blu_i = gen(seed, g, 1, 2);
  endtask

  // driver: pushes the expected hold image at each strobe
  task automatic push(input string tag);
    sb_item_t it;
    it.img = model_img();
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares hold_o one half cycle after each strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (lat_i && !rst) begin
        @(negedge clk);
        if (sbq.size() == 0) begin
          chk(0, "R8", "strobe without expected item", 0, 1);
        end else begin
          sb_item_t it;
          int mi;
          it = sbq.pop_front();
          mi = -1;
          for (int i = NT - 1; i >= 0; i--)
            if (hold_o[i*PW +: PW] !== it.img[i*PW +: PW]) mi = i;
          if (mi < 0) chk(1, it.tag, "hold", 0, 0);
          else chk(0, it.tag, $sformatf("hold triplet %0d", mi),
                   longint'(hold_o[mi*PW +: PW]), longint'(it.img[mi*PW +: PW]));
          last_img = it.img;
        end
      end
    end
  end

  task automatic strobe(input string tag);
    @(negedge clk);
    lat_i = 1'b1;
    push(tag);
    @(negedge clk);
    lat_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_line(input logic [1:0] md, input logic rv, input int seed,
                          input bit early, input int extra, input string tag);
    int ntr, ng, base, sa, sb, psa, psb, hits;
    bit dl;
    logic [PW-1:0] pa, pb, pend_a, pend_b;
    dl  = (md == 2'd0) || (md == 2'd2);
    ntr = (md == 2'd0) ? 108 : (md == 2'd1) ? 107 : (md == 2'd2) ? 104 : 103;
    ng  = dl ? ntr / 2 : ntr;
    psa = 0; psb = 0; pend_a = '0; pend_b = '0;
    @(negedge clk);
    mode_i = md; rev_i = rv; sp_left_i = 0; sp_right_i = 0;
    @(negedge clk);
    chk(sp_left_oe == rv && sp_right_oe == !rv, "R7", "pin enables",
        {sp_left_oe, sp_right_oe}, {rv, !rv});
    chk(hold_o == last_img, "R9", "hold before fill", 0, 0);
    hits = 0;
    for (int j = 0; j < ng; j++) begin
      if (j > 0) begin
        @(negedge clk);
        if (sp_left_o || sp_right_o) hits++;
      end
      if (rv) sp_right_i = (j == 0); else sp_left_i = (j == 0);
      drive_data(seed, j);
      pa = {a_blu_i, a_grn_i, a_red_i};
      pb = {b_blu_i, b_grn_i, b_red_i};
      base = dl ? 2 * j : j;
      sa = rv ? ntr - 1 - base : base;
      sb = rv ? sa - 1 : sa + 1;
      if (j < ng - 1) begin
        exp_mem[sa] = pa;
        if (dl) exp_mem[sb] = pb;
      end else begin
        psa = sa; psb = sb; pend_a = pa; pend_b = pb;
      end
    end
    @(negedge clk);
    sp_left_i = 0; sp_right_i = 0;
    drive_data(seed + 500, 0);
    chk(hits == 0, "R7", "cascade before last group", hits, 0);
    chk((rv ? sp_left_o : sp_right_o) == 1'b1 && (rv ? sp_right_o : sp_left_o) == 1'b0,
        {tag, " R2 R7"}, "cascade at last group", {sp_left_o, sp_right_o}, rv ? 2 : 1);
    if (early) begin
      lat_i = 1'b1;
      push({tag, " same-edge"});
    end
    exp_mem[psa] = pend_a;
    if (dl) exp_mem[psb] = pend_b;
    @(negedge clk);
    lat_i = 1'b0;
    chk(!sp_left_o && !sp_right_o, "R7", "cascade one cycle", {sp_left_o, sp_right_o}, 0);
    hits = 0;
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      drive_data(seed + 700, k);
      if (sp_left_o || sp_right_o) hits++;
    end
    if (extra > 0) chk(hits == 0, "R10", "no cascade after line", hits, 0);
    @(negedge clk);
    chk(hold_o == last_img, "R9", "hold before strobe", 0, 0);
    strobe(tag);
  endtask

  initial begin
    rst = 1; mode_i = 0; rev_i = 0; sp_left_i = 0; sp_right_i = 0; lat_i = 0;
    a_red_i = 0; a_grn_i = 0; a_blu_i = 0; b_red_i = 0; b_grn_i = 0; b_blu_i = 0;
    for (int i = 0; i < NT; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(hold_o == '0, "R1", "hold after reset", 0, 0);
    chk(!sp_left_o && !sp_right_o, "R1", "cascade after reset", {sp_left_o, sp_right_o}, 0);
    rst = 0;

    run_line(2'd0, 1'b0, 3,  0, 0, "R3 R6 R12");
    run_line(2'd0, 1'b1, 7,  0, 0, "R5 dual");
    run_line(2'd1, 1'b0, 11, 0, 0, "R4 R10");
    run_line(2'd3, 1'b1, 19, 0, 0, "R5 R4 single");
    run_line(2'd2, 1'b0, 23, 0, 5, "R2 R10");
    run_line(2'd0, 1'b0, 29, 1, 0, "R8");

    // R11: start pulse on the output-side pin
    @(negedge clk);
    mode_i = 2'd0; rev_i = 1'b0;
    sp_right_i = 1'b1;
    drive_data(77, 0);
    begin
      int hits = 0;
      @(negedge clk);
      sp_right_i = 1'b0;
      for (int k = 0; k < 60; k++) begin
        drive_data(78, k);
        @(negedge clk);
        if (sp_left_o || sp_right_o) hits++;
      end
      chk(hits == 0, "R11", "cascade from wrong pin", hits, 0);
    end
    strobe("R11");

    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R8", "scoreboard drained", sbq.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule